// File: doc/BRIEF.md
# Character LCD Nibble-Bus Controller

This block drives a character LCD module through a 4-bit data path plus register-select, read/write and enable lines. After reset it performs the fixed power-up routine on its own. It waits for the panel's supply to settle, forces the panel into nibble mode with a series of single-nibble writes, and then issues a short list of configuration commands. When the routine is over it raises `ready`.

Once `ready` is high, the host hands over one byte per handshake, marked as a command or as character data. Every byte leaves as two enable strobes, upper nibble first, and each strobe is followed by a settle interval. The two slow commands (clear, and return-home) are followed by their own longer intervals. All waits come from one down-counter, loaded with microsecond constants that are scaled by a clock-rate parameter. The block never reads from the panel.

Top module: `lcd4_ctrl`

## Requirements
- R1: A byte is sent as two enable pulses, with bits 7..4 on `lcd_db` for the first pulse and bits 3..0 for the second. `lcd_db` and `lcd_rs` do not change while `lcd_en` is high, so the panel captures a stable value on the falling edge of `lcd_en`.
- R2: `lcd_rw` is 0 at all times. `lcd_rs` equals `req_rs` for a host byte: 0 marks a command and 1 marks character data.
- R3: Every high phase of `lcd_en` lasts at least `EN_HIGH_NS` nanoseconds, rounded up to whole clock cycles (minimum one cycle).
- R4: After any falling edge of `lcd_en`, at least 40 us (40×`CLK_MHZ` cycles) pass before the next rising edge.
- R5: After reset is released there is no strobe for 20 ms. Then four single-nibble writes with `lcd_rs`=0 follow, with the values 3, 3, 3, 2. The gap after each of them is at least 4100 us, 100 us, 40 us and 40 us respectively.
- R6: The initialisation then sends the command bytes 0x28, 0x08, 0x01, 0x06 and 0x0C, in that order, with `lcd_rs`=0. Only after that does `ready` rise.
- R7: Command 0x01 (clear) is followed by at least 2000 us, and commands 0x02 and 0x03 (home) by at least 1600 us, before the next strobe or before `ready` returns. Every other byte ends with 40 us. `ready` returns no more than three cycles after its byte's final interval has run out.
- R8: `ready` is low during initialisation, and from the cycle after a request is accepted until the final interval of that byte has run out. A request is accepted in a cycle where `req_valid` and `ready` are both high, and its first `lcd_en` rise follows within two cycles.
- R9: A request presented while `ready` is low is ignored: it produces no strobe and does not alter the bytes that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a byte |
| req_rs | input | 1 | 0 = command byte, 1 = character byte |
| req_data | input | 8 | Byte to send |
| ready | output | 1 | Block idle and able to accept a byte |
| lcd_rs | output | 1 | Register-select line |
| lcd_rw | output | 1 | Read/write line (always write) |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 4 | Data lines DB7..DB4 |

## Verification
The hardest case to create is a request that arrives while the block is busy, because an ignored request leaves no trace unless it happens to collide with the moment `ready` returns. The stimulus therefore holds `req_valid` high with a recognisable character byte for thousands of cycles during the power-up waits and for a window after every accepted byte. The value it offers is chosen at each falling clock edge from the `ready` level seen at that moment. Any stray acceptance shows up as an unexpected or mismatched strobe against the queue of expected nibbles. The same queue carries the minimum gap owed after each strobe, so the clear/home intervals and the 20 ms power-up wait are measured edge to edge.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

    localparam int US_W = 15;

    localparam int PWR_US   = 20000;
    localparam int FIRST_US = 4100;
    localparam int SECOND_US = 100;
    localparam int CYC_US   = 40;
    localparam int CLR_US   = 2000;
    localparam int HOME_US  = 1600;

    localparam int INIT_STEPS = 10;

    typedef enum logic [1:0] {
        OP_WAIT = 2'd0,
        OP_NIB  = 2'd1,
        OP_BYTE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SETUP = 2'd1,
        TX_HIGH  = 2'd2,
        TX_WAIT  = 2'd3
    } tx_state_e;

    typedef struct packed {
        op_e             op;
        logic            rs;
        logic [7:0]      val;
        logic [US_W-1:0] us;
    } job_t;

    function automatic job_t mk_job(input op_e o, input logic [7:0] v, input int u);
        job_t j;
        j.op  = o;
        j.rs  = 1'b0;
        j.val = v;
        j.us  = US_W'(u);
        return j;
    endfunction

    function automatic job_t init_job(input int idx);
        case (idx)
            0:       return mk_job(OP_WAIT, 8'h00, PWR_US);
            1:       return mk_job(OP_NIB,  8'h03, FIRST_US);
            2:       return mk_job(OP_NIB,  8'h03, SECOND_US);
            3:       return mk_job(OP_NIB,  8'h03, CYC_US);
            4:       return mk_job(OP_NIB,  8'h02, CYC_US);
            5:       return mk_job(OP_BYTE, 8'h28, 0);
            6:       return mk_job(OP_BYTE, 8'h08, 0);
            7:       return mk_job(OP_BYTE, 8'h01, 0);
            8:       return mk_job(OP_BYTE, 8'h06, 0);
            default: return mk_job(OP_BYTE, 8'h0C, 0);
        endcase
    endfunction

    function automatic logic [US_W-1:0] tail_us(input logic rs, input logic [7:0] v);
        if (!rs && v == 8'h01)
            return US_W'(CLR_US);
        else if (!rs && v[7:1] == 7'b0000001)
            return US_W'(HOME_US);
        else
            return US_W'(CYC_US);
    endfunction

    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/lcd4_timer.sv
module lcd4_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcd4_init_seq.sv
module lcd4_init_seq
    import lcd4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic job_ready,
    output logic job_valid,
    output job_t job,
    output logic done
);
    localparam int IW = $clog2(INIT_STEPS);

    logic [IW-1:0] idx;

    assign job       = init_job(int'(idx));
    assign job_valid = !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            done <= 1'b0;
        end else if (job_valid && job_ready) begin
            if (idx == IW'(INIT_STEPS - 1))
                done <= 1'b1;
            else
                idx <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/lcd4_nib_tx.sv
module lcd4_nib_tx
    import lcd4_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int EN_HIGH_NS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       job_valid,
    input  job_t       job,
    output logic       job_ready,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic [3:0] lcd_db
);
    localparam int TW     = $clog2(PWR_US * CLK_MHZ + 1) + 1;
    localparam int EN_CYC = ns_to_cyc(EN_HIGH_NS, CLK_MHZ);
    localparam logic [TW-1:0] MHZ_V = TW'(CLK_MHZ);

    function automatic logic [TW-1:0] us_cyc(input logic [US_W-1:0] u);
        return TW'(u) * MHZ_V - TW'(1);
    endfunction

    tx_state_e       state;
    job_t            cur;
    logic            low_half;
    logic [3:0]      db_q;
    logic            rs_q;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic [US_W-1:0] post_us;

    lcd4_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        if (cur.op == OP_BYTE && !low_half)
            post_us = US_W'(CYC_US);
        else if (cur.op == OP_BYTE)
            post_us = tail_us(cur.rs, cur.val);
        else
            post_us = cur.us;
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            TX_IDLE: begin
                if (job_valid && job.op == OP_WAIT) begin
                    tmr_load = 1'b1;
                    tmr_val  = us_cyc(job.us);
                end
            end
            TX_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(EN_CYC - 1);
            end
            TX_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = us_cyc(post_us);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            cur      <= '0;
            low_half <= 1'b0;
            db_q     <= '0;
            rs_q     <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (job_valid) begin
                        cur      <= job;
                        low_half <= 1'b0;
                        rs_q     <= job.rs;
                        db_q     <= (job.op == OP_NIB) ? job.val[3:0] : job.val[7:4];
                        state    <= (job.op == OP_WAIT) ? TX_WAIT : TX_SETUP;
                    end
                end
                TX_SETUP: state <= TX_HIGH;
                TX_HIGH: begin
                    if (tmr_done)
                        state <= TX_WAIT;
                end
                TX_WAIT: begin
                    if (tmr_done) begin
                        if (cur.op == OP_BYTE && !low_half) begin
                            low_half <= 1'b1;
                            db_q     <= cur.val[3:0];
                            state    <= TX_SETUP;
                        end else begin
                            state <= TX_IDLE;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign job_ready = (state == TX_IDLE);
    assign lcd_en    = (state == TX_HIGH);
    assign lcd_db    = db_q;
    assign lcd_rs    = rs_q;
endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
    import lcd4_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int EN_HIGH_NS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic [7:0] req_data,
    output logic       ready,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [3:0] lcd_db
);
    logic init_valid;
    job_t init_job_w;
    logic init_done;
    logic tx_ready;
    logic tx_valid;
    job_t tx_job;
    job_t host_job;

    lcd4_init_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .job_ready (tx_ready),
        .job_valid (init_valid),
        .job       (init_job_w),
        .done      (init_done)
    );

    always_comb begin
        host_job.op  = OP_BYTE;
        host_job.rs  = req_rs;
        host_job.val = req_data;
        host_job.us  = '0;
    end

    assign tx_valid = init_done ? req_valid : init_valid;
    assign tx_job   = init_done ? host_job  : init_job_w;

    lcd4_nib_tx #(
        .CLK_MHZ    (CLK_MHZ),
        .EN_HIGH_NS (EN_HIGH_NS)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .job_valid (tx_valid),
        .job       (tx_job),
        .job_ready (tx_ready),
        .lcd_rs    (lcd_rs),
        .lcd_en    (lcd_en),
        .lcd_db    (lcd_db)
    );

    assign ready  = init_done && tx_ready;
    assign lcd_rw = 1'b0;
endmodule

// File: rtl/lcd4_ctrl_chk.sv
module lcd4_ctrl_chk
    import lcd4_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int EN_HIGH_NS = 500
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       ready,
    input logic       lcd_rs,
    input logic       lcd_en,
    input logic [3:0] lcd_db
);
    localparam logic [31:0] MIN_GAP = 32'(CYC_US * CLK_MHZ);
    localparam logic [31:0] PWR_GAP = 32'(PWR_US * CLK_MHZ);
    localparam logic [31:0] EN_MIN  = 32'(ns_to_cyc(EN_HIGH_NS, CLK_MHZ));

    logic [31:0] lo_cnt;
    logic [31:0] hi_cnt;
    logic [31:0] since_rst;
    logic        seen_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= '0;
            hi_cnt    <= '0;
            since_rst <= '0;
            seen_fall <= 1'b0;
        end else begin
            if (since_rst != '1) since_rst <= since_rst + 32'd1;
            if (lcd_en) begin
                lo_cnt <= '0;
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 32'd1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != '1) lo_cnt <= lo_cnt + 32'd1;
                if (hi_cnt != '0) seen_fall <= 1'b1;
            end
        end
    end

    a_r1_stable_while_en: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    a_r3_en_width: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (hi_cnt >= EN_MIN));

    a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
        ($rose(lcd_en) && seen_fall) |-> (lo_cnt >= MIN_GAP));

    a_r5_power_wait: assert property (@(posedge clk) disable iff (rst)
        ($rose(lcd_en) && !seen_fall) |-> (since_rst >= PWR_GAP));

    a_r8_busy_during_en: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> !ready);

    a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> !ready);
endmodule

bind lcd4_ctrl lcd4_ctrl_chk #(
    .CLK_MHZ    (CLK_MHZ),
    .EN_HIGH_NS (EN_HIGH_NS)
) u_lcd4_ctrl_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready     (ready),
    .lcd_rs    (lcd_rs),
    .lcd_en    (lcd_en),
    .lcd_db    (lcd_db)
);

// File: tb/test_lcd4_ctrl.sv
module test_lcd4_ctrl;
    localparam int M      = 2;
    localparam int EN_NS  = 1000;
    localparam int EN_CYC = 2;
    localparam int LIMIT  = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_rs;
    logic [7:0] req_data;
    logic       ready;
    logic       lcd_rs;
    logic       lcd_rw;
    logic       lcd_en;
    logic [3:0] lcd_db;

    always #2 clk = ~clk;

    lcd4_ctrl #(.CLK_MHZ(M), .EN_HIGH_NS(EN_NS)) i_lcd4_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rs(req_rs),
        .req_data(req_data), .ready(ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_en(lcd_en), .lcd_db(lcd_db)
    );

    int n_chk  = 0;
    int n_fail = 0;

    bit    q_rs[$];
    int    q_nib[$];
    int    q_gap[$];
    string q_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void push_nib(input bit r, input int nib, input int gap_us, input string tag);
        q_rs.push_back(r);
        q_nib.push_back(nib);
        q_gap.push_back(gap_us * M);
        q_tag.push_back(tag);
    endfunction

    function automatic int tail(input bit r, input int v);
        if (!r && v == 1) return 2000;
        if (!r && (v == 2 || v == 3)) return 1600;
        return 40;
    endfunction

    function automatic void push_byte(input bit r, input int v, input string tag);
        push_nib(r, (v >> 4) & 15, 40, tag);
        push_nib(r, v & 15, tail(r, v), tag);
    endfunction

    // monitor: reference of strobe order, values and minimum gaps
    bit    prev_en, prev_ready, cap_rs;
    int    cap_db, low_cnt, hi_cnt, req_gap, cycles;
    string gap_tag;

    always @(negedge clk) begin
        if (rst) begin
            prev_en    = 1'b0;
            prev_ready = 1'b0;
            low_cnt    = 0;
            hi_cnt     = 0;
            req_gap    = 20000 * M;
            gap_tag    = "R5";
        end else begin
            cycles++;
            check(lcd_rw === 1'b0, "R2 rw", int'(lcd_rw), 0);
            if (lcd_en && !prev_en) begin
                check(low_cnt >= req_gap, {gap_tag, " gap before strobe"}, low_cnt, req_gap);
                cap_rs = lcd_rs;
                cap_db = int'(lcd_db);
                hi_cnt = 1;
            end else if (lcd_en) begin
                hi_cnt++;
                check(lcd_rs === cap_rs && int'(lcd_db) == cap_db, "R1 stable while en",
                      int'(lcd_db), cap_db);
            end
            if (!lcd_en && prev_en) begin
                check(hi_cnt >= EN_CYC, "R3 en width", hi_cnt, EN_CYC);
                if (q_nib.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", cap_db, -1);
                    req_gap = 40 * M;
                    gap_tag = "R4";
                end else begin
                    check(cap_rs == q_rs[0], {q_tag[0], " rs"}, int'(cap_rs), int'(q_rs[0]));
                    check(cap_db == q_nib[0], {q_tag[0], " nibble"}, cap_db, q_nib[0]);
                    req_gap = q_gap[0];
                    gap_tag = (q_gap[0] > 40 * M) ? q_tag[0] : "R4";
                    void'(q_rs.pop_front());
                    void'(q_nib.pop_front());
                    void'(q_gap.pop_front());
                    void'(q_tag.pop_front());
                end
                low_cnt = 1;
            end else if (!lcd_en) begin
                low_cnt++;
            end
            if (q_nib.size() != 0 || low_cnt < req_gap)
                check(ready === 1'b0, "R8 ready low while busy", int'(ready), 0);
            if (ready && !prev_ready)
                check(low_cnt <= req_gap + 3, "R7 ready returns promptly", low_cnt, req_gap + 3);
            prev_en    = lcd_en;
            prev_ready = ready;
            if (cycles > LIMIT) begin
                check(1'b0, "watchdog", cycles, LIMIT);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    task automatic poke_busy(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = !ready;
            req_rs    = 1'b1;
            req_data  = 8'hA5;
        end
        req_valid = 1'b0;
    endtask

    task automatic send(input bit r, input logic [7:0] v, input string tag);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_rs    = r;
        req_data  = v;
        @(posedge clk);
        #1;
        push_byte(r, int'(v), tag);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!lcd_en && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(n <= 2, "R8 start latency", n, 2);
        poke_busy(30);
    endtask

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_rs    = 1'b0;
        req_data  = 8'h00;
        cycles    = 0;
        // R5: nibble-mode entry; R6: configuration bytes
        push_nib(1'b0, 3, 4100, "R5");
        push_nib(1'b0, 3, 100,  "R5");
        push_nib(1'b0, 3, 40,   "R5");
        push_nib(1'b0, 2, 40,   "R5");
        push_byte(1'b0, 'h28, "R6");
        push_byte(1'b0, 'h08, "R6");
        push_byte(1'b0, 'h01, "R6");
        push_byte(1'b0, 'h06, "R6");
        push_byte(1'b0, 'h0C, "R6");
        repeat (4) @(negedge clk);
        check(lcd_en === 1'b0 && ready === 1'b0, "R8 reset state", int'(ready), 0);
        check(lcd_rw === 1'b0, "R2 reset rw", int'(lcd_rw), 0);
        rst = 1'b0;
        poke_busy(3000);                   // R9 during power-up wait
        send(1'b1, 8'h48, "R2 char");
        send(1'b1, 8'hB7, "R1 char");
        send(1'b0, 8'h01, "R7 clear");
        send(1'b1, 8'h00, "R2 char");
        send(1'b0, 8'h02, "R7 home");
        send(1'b0, 8'h03, "R7 home");
        send(1'b0, 8'h80, "R2 cmd");
        send(1'b1, 8'hFF, "R1 char");
        @(negedge clk);
        while (q_nib.size() != 0 || !ready) @(negedge clk);
        repeat (5) @(negedge clk);
        check(ready === 1'b1, "R9 idle after ignored requests", int'(ready), 1);
        check(q_nib.size() == 0, "R9 all strobes seen", q_nib.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule